// File: doc/BRIEF.md
# Privilege-Filtered Hart Event Counters

This block keeps three 64-bit event counters for one hart: a clock-cycle counter, a retired-instruction counter and a trap-event counter (the last one present only when the `HAS_TRAP` parameter is set). Each counter has its own five-bit inhibit mask, with one bit for each privilege mode. When the mask bit for the mode an event is attributed to is set, the counter holds its value.

The retired-instruction counter follows precise retirement rules. The pipeline reports one retiring instruction per cycle together with the mode it executed in. An instruction marked as raising a synchronous exception never counts; this covers ECALL, EBREAK and faulting instructions. A return-from-trap instruction counts under the mode it started in, whatever mode the hart switches to. Interrupts and exceptions are reported on a separate trap port. They are attributed to the mode the trap enters, and they feed only the trap-event counter.

Software reads and writes the counters through a 32-bit register port. The port exposes each counter as a low half and a high half, plus one filter word. Reads are combinational.

Top module: `hpc_unit`

## Requirements
- R1: After reset all three counters and all inhibit masks read as zero.
- R2: The cycle counter adds one on every clock unless the inhibit bit of `cur_mode` in its mask is set. The mask occupies filter word bits [4:0], and the bit index is the mode code: M=0, S=1, U=2, VS=3, VU=4.
- R3: The retired-instruction counter adds one in a cycle with `ret_valid`=1 and `ret_exc`=0, unless the bit of `ret_mode` in its mask (filter bits [12:8]) is set.
- R4: A retirement flagged `ret_exc`=1 never changes the retired-instruction counter, and neither does `trap_valid`. A faulting instruction that is later re-issued and retires is therefore counted exactly once.
- R5: A return-from-trap retirement (`ret_xret`=1) is counted and filtered by `ret_mode`, independent of `cur_mode` in the same cycle.
- R6: The trap-event counter adds one on each `trap_valid` cycle, unless the bit of `trap_dst_mode` in its mask (filter bits [20:16]) is set.
- R7: Each counter is a true 64-bit counter. It carries from the low half into the high half and wraps from all ones to zero.
- R8: A write to one half of a counter takes priority over an increment in the same cycle. The other half keeps its previous value.
- R9: The register port maps addresses as follows: 0/1 cycle low/high, 2/3 retired low/high, 4/5 trap low/high, 6 filter word. Address 7 reads zero. Filter bits outside the three masks read zero.
- R10: Mode codes 5 to 7 never inhibit any counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted in step with clk |
| cur_mode | input | 3 | Current hart privilege mode, used to filter the cycle counter |
| ret_valid | input | 1 | An instruction leaves the pipeline this cycle |
| ret_exc | input | 1 | That instruction raised a synchronous exception (includes ECALL/EBREAK) |
| ret_xret | input | 1 | That instruction is a return from trap |
| ret_mode | input | 3 | Mode the retiring instruction executed in |
| trap_valid | input | 1 | An interrupt or exception is taken this cycle |
| trap_dst_mode | input | 3 | Mode the trap enters |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | 3 | Register address |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data for `csr_addr` |

## Verification
Two functions can fall in the same cycle: a software write to one counter half, and a hardware increment of that same counter. The bench provokes this directly by writing the low half of the retired-instruction counter while a valid retirement is presented. Randomized traffic then makes writes coincide with retirements, traps and filter changes. In each such cycle the written half must hold exactly the written data and the other half its old value, with no increment or carry applied. A filter write in the same cycle as an event must still use the old mask for that event.

// File: rtl/hpc_pkg.sv
package hpc_pkg;
  localparam int MODE_W    = 3;
  localparam int NUM_MODES = 5;
  localparam int NUM_CTR   = 3;
  localparam int ADDR_W    = 3;
  localparam int FIELD_STR = 8;

  typedef enum logic [MODE_W-1:0] {
    MODE_M  = 3'd0,
    MODE_S  = 3'd1,
    MODE_U  = 3'd2,
    MODE_VS = 3'd3,
    MODE_VU = 3'd4
  } hpc_mode_e;

  localparam int CTR_CYC = 0;
  localparam int CTR_RET = 1;
  localparam int CTR_TRP = 2;

  localparam logic [ADDR_W-1:0] ADDR_FILT = 3'd6;
endpackage

// File: rtl/hpc_mode_gate.sv
module hpc_mode_gate
  import hpc_pkg::*;
(
  input  logic [NUM_MODES-1:0] mask,
  input  logic [MODE_W-1:0]    mode,
  output logic                 inhibit
);
  logic [NUM_MODES-1:0] mode_oh;

  always_comb begin
    mode_oh = '0;
    for (int m = 0; m < NUM_MODES; m++) begin
      if (mode == MODE_W'(m)) mode_oh[m] = 1'b1;
    end
  end

  assign inhibit = |(mask & mode_oh);
endmodule

// File: rtl/hpc_ctr.sv
module hpc_ctr #(
  parameter int CW = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            inc,
  input  logic            wr_lo,
  input  logic            wr_hi,
  input  logic [CW/2-1:0] wdata,
  output logic [CW-1:0]   cnt
);
  localparam int HW = CW / 2;

  logic [CW-1:0] cnt_q, cnt_d, sum;
  logic          en;

  assign sum = cnt_q + CW'(1);
  assign en  = inc | wr_lo | wr_hi;

  always_comb begin
    cnt_d = cnt_q;
    if (wr_lo) begin
      cnt_d[HW-1:0] = wdata;
    end else if (wr_hi) begin
      cnt_d[CW-1:HW] = wdata;
    end else if (inc) begin
      cnt_d = sum;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;

  // R7: carry from the low half into the high half
  p_carry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !wr_lo && !wr_hi && (&cnt_q[HW-1:0]))
    |=> (cnt_q[HW-1:0] == '0) && (cnt_q[CW-1:HW] == $past(cnt_q[CW-1:HW]) + HW'(1)));

  // R8: low-half write wins, high half preserved
  p_wr_lo_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> (cnt_q[HW-1:0] == $past(wdata)) && $stable(cnt_q[CW-1:HW]));

  // R8: high-half write wins, low half preserved
  p_wr_hi_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi && !wr_lo) |=> (cnt_q[CW-1:HW] == $past(wdata)) && $stable(cnt_q[HW-1:0]));

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !wr_lo && !wr_hi) |=> $stable(cnt_q));
endmodule

// File: rtl/hpc_regs.sv
module hpc_regs
  import hpc_pkg::*;
#(
  parameter int  CW       = 64,
  parameter bit  HAS_TRAP = 1'b1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              csr_we,
  input  logic [ADDR_W-1:0]                 csr_addr,
  input  logic [CW/2-1:0]                   csr_wdata,
  input  logic [NUM_CTR-1:0][CW-1:0]        cnt,
  output logic [NUM_CTR-1:0]                wr_lo,
  output logic [NUM_CTR-1:0]                wr_hi,
  output logic [NUM_CTR-1:0][NUM_MODES-1:0] mask,
  output logic [CW/2-1:0]                   csr_rdata
);
  localparam int HW = CW / 2;

  logic [NUM_CTR-1:0][NUM_MODES-1:0] mask_q, mask_d;
  logic                              filt_we;

  assign filt_we = csr_we && (csr_addr == ADDR_FILT);

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_dec
    assign wr_lo[i] = csr_we && (csr_addr == ADDR_W'(2 * i));
    assign wr_hi[i] = csr_we && (csr_addr == ADDR_W'(2 * i + 1));
  end

  always_comb begin
    mask_d = mask_q;
    if (filt_we) begin
      for (int i = 0; i < NUM_CTR; i++) begin
        mask_d[i] = csr_wdata[i*FIELD_STR +: NUM_MODES];
      end
      if (!HAS_TRAP) mask_d[CTR_TRP] = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (filt_we) begin
      mask_q <= mask_d;
    end
  end

  assign mask = mask_q;

  always_comb begin
    csr_rdata = '0;
    for (int i = 0; i < NUM_CTR; i++) begin
      if (csr_addr == ADDR_W'(2 * i))     csr_rdata = cnt[i][HW-1:0];
      if (csr_addr == ADDR_W'(2 * i + 1)) csr_rdata = cnt[i][CW-1:HW];
    end
    if (csr_addr == ADDR_FILT) begin
      for (int i = 0; i < NUM_CTR; i++) begin
        csr_rdata[i*FIELD_STR +: NUM_MODES] = mask_q[i];
      end
    end
  end

  // R9: masks change only through a filter write
  p_mask_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(csr_we && (csr_addr == ADDR_FILT)) |=> $stable(mask_q));

  // R8: at most one half strobe active at a time
  p_one_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_lo, wr_hi}));
endmodule

// File: rtl/hpc_unit.sv
module hpc_unit
  import hpc_pkg::*;
#(
  parameter int CW       = 64,
  parameter bit HAS_TRAP = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cur_mode,
  input  logic              ret_valid,
  input  logic              ret_exc,
  input  logic              ret_xret,
  input  logic [2:0]        ret_mode,
  input  logic              trap_valid,
  input  logic [2:0]        trap_dst_mode,
  input  logic              csr_we,
  input  logic [2:0]        csr_addr,
  input  logic [CW/2-1:0]   csr_wdata,
  output logic [CW/2-1:0]   csr_rdata
);
  logic [NUM_CTR-1:0][CW-1:0]        cnt;
  logic [NUM_CTR-1:0][NUM_MODES-1:0] mask;
  logic [NUM_CTR-1:0][MODE_W-1:0]    ev_mode;
  logic [NUM_CTR-1:0]                ev_hit, inh, inc, wr_lo, wr_hi;

  // event sources and the mode each one is attributed to
  assign ev_mode[CTR_CYC] = cur_mode;
  assign ev_hit[CTR_CYC]  = 1'b1;
  assign ev_mode[CTR_RET] = ret_mode;
  assign ev_hit[CTR_RET]  = ret_valid && !ret_exc;
  assign ev_mode[CTR_TRP] = trap_dst_mode;
  assign ev_hit[CTR_TRP]  = trap_valid;

  hpc_regs #(.CW(CW), .HAS_TRAP(HAS_TRAP)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .csr_we    (csr_we),
    .csr_addr  (csr_addr),
    .csr_wdata (csr_wdata),
    .cnt       (cnt),
    .wr_lo     (wr_lo),
    .wr_hi     (wr_hi),
    .mask      (mask),
    .csr_rdata (csr_rdata)
  );

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    hpc_mode_gate u_gate (
      .mask    (mask[i]),
      .mode    (ev_mode[i]),
      .inhibit (inh[i])
    );
    assign inc[i] = ev_hit[i] && !inh[i];

    if (i == CTR_TRP && !HAS_TRAP) begin : g_absent
      assign cnt[i] = '0;
    end else begin : g_present
      hpc_ctr #(.CW(CW)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (inc[i]),
        .wr_lo (wr_lo[i]),
        .wr_hi (wr_hi[i]),
        .wdata (csr_wdata),
        .cnt   (cnt[i])
      );
    end
  end

  logic ret_wr, cyc_wr;
  assign ret_wr = wr_lo[CTR_RET] | wr_hi[CTR_RET];
  assign cyc_wr = wr_lo[CTR_CYC] | wr_hi[CTR_CYC];

  // R2: inhibited cycle counter holds
  p_cyc_inhibit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (inh[CTR_CYC] && !cyc_wr) |=> $stable(cnt[CTR_CYC]));

  // R3: an unfiltered retirement adds one
  p_ret_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && !ret_exc && !inh[CTR_RET] && !ret_wr)
    |=> cnt[CTR_RET] == $past(cnt[CTR_RET]) + CW'(1));

  // R4: exceptions and traps leave the retired count alone
  p_exc_no_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((!ret_valid || ret_exc) && !ret_wr) |=> $stable(cnt[CTR_RET]));

  // R5: return-from-trap judged by its originating mode
  p_xret_origin_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && ret_xret && !ret_exc && !ret_wr && (cur_mode != ret_mode)
     && !(|(mask[CTR_RET] >> ret_mode)) == 1'b0 ? 1'b0 :
     (ret_valid && ret_xret && !ret_exc && !ret_wr && !inh[CTR_RET]))
    |=> cnt[CTR_RET] != $past(cnt[CTR_RET]));

  // R10: reserved mode codes never inhibit
  p_reserved_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && !ret_exc && (ret_mode > 3'd4) && !ret_wr)
    |=> cnt[CTR_RET] == $past(cnt[CTR_RET]) + CW'(1));

  if (HAS_TRAP) begin : g_trap_chk
    logic trp_wr;
    assign trp_wr = wr_lo[CTR_TRP] | wr_hi[CTR_TRP];
    // R6: trap events filtered by the destination mode
    p_trap_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!trp_wr && !(trap_valid && !inh[CTR_TRP])) |=> $stable(cnt[CTR_TRP]));
  end
endmodule

// File: tb/hpc_unit_tb.sv
module hpc_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  cur_mode, ret_mode, trap_dst_mode, csr_addr;
  logic        ret_valid, ret_exc, ret_xret, trap_valid, csr_we;
  logic [31:0] csr_wdata, csr_rdata;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [63:0] m_cnt [3];
  logic [4:0]  m_msk [3];

  always #10 clk = ~clk;

  hpc_unit u_dut (
    .clk(clk), .rst_n(rst_n), .cur_mode(cur_mode), .ret_valid(ret_valid),
    .ret_exc(ret_exc), .ret_xret(ret_xret), .ret_mode(ret_mode),
    .trap_valid(trap_valid), .trap_dst_mode(trap_dst_mode), .csr_we(csr_we),
    .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata)
  );

  function automatic bit m_inh(int k, logic [2:0] md);
    if (md < 3'd5) return m_msk[k][md];
    return 1'b0;
  endfunction

  function automatic logic [31:0] m_read(logic [2:0] a);
    logic [31:0] v = '0;
    if (a < 3'd6) v = a[0] ? m_cnt[a >> 1][63:32] : m_cnt[a >> 1][31:0];
    else if (a == 3'd6) begin
      v[4:0] = m_msk[0]; v[12:8] = m_msk[1]; v[20:16] = m_msk[2];
    end
    return v;
  endfunction

  // behavioural update for one clock edge, from the requirements
  task automatic model_edge();
    bit ev [3];
    ev[0] = !m_inh(0, cur_mode);
    ev[1] = ret_valid && !ret_exc && !m_inh(1, ret_mode);
    ev[2] = trap_valid && !m_inh(2, trap_dst_mode);
    for (int k = 0; k < 3; k++) begin
      if (csr_we && csr_addr == 3'(2 * k))          m_cnt[k][31:0]  = csr_wdata;
      else if (csr_we && csr_addr == 3'(2 * k + 1)) m_cnt[k][63:32] = csr_wdata;
      else if (ev[k])                               m_cnt[k] = m_cnt[k] + 64'd1;
    end
    if (csr_we && csr_addr == 3'd6) begin
      m_msk[0] = csr_wdata[4:0]; m_msk[1] = csr_wdata[12:8]; m_msk[2] = csr_wdata[20:16];
    end
  endtask

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic rd(logic [2:0] a, string tag);
    csr_addr = a; csr_we = 1'b0;
    #1;
    chk(tag, csr_rdata, m_read(a));
  endtask

  task automatic rd_all(string tag);
    for (int a = 0; a < 8; a++) rd(3'(a), tag);
  endtask

  task automatic quiet();
    ret_valid = 0; ret_exc = 0; ret_xret = 0; trap_valid = 0; csr_we = 0;
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    quiet();
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    csr_we = 1'b1; csr_addr = a; csr_wdata = d;
    step();
  endtask

  task automatic retire(logic [2:0] md, bit exc, bit xr);
    ret_valid = 1'b1; ret_mode = md; ret_exc = exc; ret_xret = xr;
    step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cur_mode = 3'd0; ret_mode = 3'd0; trap_dst_mode = 3'd0;
    csr_addr = 3'd0; csr_wdata = '0;
    quiet();
    for (int k = 0; k < 3; k++) begin m_cnt[k] = '0; m_msk[k] = '0; end
    repeat (3) @(negedge clk);
    rd_all("R1");
    rst_n = 1'b1;

    // R2: free-running cycle count in M
    repeat (5) step();
    rd(3'd0, "R2");
    // R2: inhibit U, run in U
    wr(3'd6, 32'h0000_0004);
    cur_mode = 3'd2;
    repeat (4) step();
    rd(3'd0, "R2");
    cur_mode = 3'd1;
    step();
    rd(3'd0, "R2");

    // R3: retire in S, inhibit in U
    wr(3'd6, 32'h0000_0400);
    retire(3'd1, 0, 0); retire(3'd1, 0, 0);
    rd(3'd2, "R3");
    retire(3'd2, 0, 0);
    rd(3'd2, "R3");

    // R4: exceptions, then fault-and-retry counts once
    retire(3'd1, 1, 0);
    rd(3'd2, "R4");
    retire(3'd1, 1, 0); retire(3'd1, 0, 0);
    rd(3'd2, "R4");
    trap_valid = 1'b1; trap_dst_mode = 3'd0;
    step();
    rd(3'd2, "R4");
    rd(3'd4, "R6");

    // R5: return-from-trap in S while hart already shows U (U inhibited)
    cur_mode = 3'd2;
    retire(3'd1, 0, 1);
    rd(3'd2, "R5");
    retire(3'd2, 0, 1);
    rd(3'd2, "R5");

    // R6: trap into S inhibited, into VS counted
    wr(3'd6, 32'h0002_0000);
    trap_valid = 1'b1; trap_dst_mode = 3'd1; step();
    trap_valid = 1'b1; trap_dst_mode = 3'd3; step();
    rd(3'd4, "R6");
    rd(3'd5, "R6");

    // R10: reserved mode with every mask bit set
    wr(3'd6, 32'h001F_1F1F);
    rd(3'd6, "R9");
    retire(3'd7, 0, 0);
    trap_valid = 1'b1; trap_dst_mode = 3'd5; step();
    rd(3'd2, "R10");
    rd(3'd4, "R10");
    cur_mode = 3'd6; step();
    rd(3'd0, "R10");
    wr(3'd6, 32'hFFFF_FFFF);
    rd(3'd6, "R9");
    rd(3'd7, "R9");
    wr(3'd6, 32'h0);

    // R7: wrap of the full 64-bit value
    wr(3'd2, 32'hFFFF_FFFF); wr(3'd3, 32'hFFFF_FFFF);
    retire(3'd0, 0, 0);
    rd(3'd2, "R7"); rd(3'd3, "R7");
    wr(3'd2, 32'hFFFF_FFFF); wr(3'd3, 32'h0000_0010);
    retire(3'd0, 0, 0);
    rd(3'd2, "R7"); rd(3'd3, "R7");

    // R8: write collides with an increment that would carry
    wr(3'd2, 32'hFFFF_FFFF);
    ret_valid = 1'b1; ret_mode = 3'd0; csr_we = 1'b1; csr_addr = 3'd2; csr_wdata = 32'h0000_1234;
    step();
    rd(3'd2, "R8"); rd(3'd3, "R8");
    ret_valid = 1'b1; ret_mode = 3'd0; csr_we = 1'b1; csr_addr = 3'd3; csr_wdata = 32'hABCD_0000;
    step();
    rd(3'd2, "R8"); rd(3'd3, "R8");

    // mixed traffic, every register compared after every edge
    for (int n = 0; n < 3000; n++) begin
      cur_mode      = 3'($urandom_range(0, 7));
      ret_valid     = 1'($urandom);
      ret_exc       = ($urandom_range(0, 3) == 0);
      ret_xret      = ($urandom_range(0, 7) == 0);
      ret_mode      = 3'($urandom_range(0, 7));
      trap_valid    = ($urandom_range(0, 3) == 0);
      trap_dst_mode = 3'($urandom_range(0, 7));
      csr_we        = ($urandom_range(0, 7) == 0);
      csr_addr      = 3'($urandom_range(0, 7));
      csr_wdata     = ($urandom_range(0, 3) == 0) ? 32'hFFFF_FFFF : $urandom;
      step();
      rd_all("R8");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule